// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor core that executes a small load/store instruction subset. Each instruction spends a varying number of clock cycles in the shared datapath. Every instruction passes through a common fetch state and a common decode state. After decode the block follows a path chosen by the instruction class, and each path ends back in fetch. In every cycle it drives the strobes and multiplexer selects of the external datapath. That datapath holds the ALU, the register file, the memory, the program counter, the instruction register and the exception registers.

The block takes two inputs. The first is the 6-bit opcode field, taken from the instruction register, which holds it from decode until the next fetch. The second is the overflow flag of the ALU. The block supports word load, word store, register-to-register arithmetic, branch-if-equal and jump. Two extra states trap instructions it does not recognise and arithmetic overflow. In both cases the faulting instruction address (the program counter minus four) and a cause code are saved, and the program counter is redirected to a fixed handler address. The state number is also an output, so that a core or a test can watch the sequence.

Top module: `multicycleControl`

## Requirements
- R1: A synchronous active-high reset puts the state in fetch (code 0). While reset is high, every strobe and select output is 0: the write enables pcWrite, pcWriteCond, irWrite, regWrite, memWrite, epcWrite and causeWrite, memRead, and all selects. The first cycle after release is a fetch.
- R2: Fetch (0) drives memRead=1, irWrite=1, pcWrite=1, memAddrSel=0, aluSrcA=0, aluSrcB=01, aluOp=00 and pcSource=00, and the next state is decode (1). In every state, any output not named for it in R2 to R10 is 0.
- R3: Decode (1) drives aluSrcA=0, aluSrcB=11 and aluOp=00, with no write. Its next state depends on the opcode: 100011 (load) or 101011 (store) goes to address computation (2), 000000 goes to execute (6), 000100 goes to branch (8), 000010 goes to jump (9), and any other opcode goes to the undefined-instruction state (10).
- R4: Address computation (2) drives aluSrcA=1, aluSrcB=10 and aluOp=00. A load continues to memory read (3), which drives memRead=1 and memAddrSel=1. It then goes to load writeback (4), which drives regWrite=1, wbFromMem=1 and destFromRd=0, and returns to fetch. A load takes five cycles.
- R5: For a store, address computation (2) is followed by memory write (5), which drives memWrite=1 and memAddrSel=1 and returns to fetch. A store takes four cycles.
- R6: Execute (6) drives aluSrcA=1, aluSrcB=00 and aluOp=10. Without overflow it goes to register writeback (7), which drives regWrite=1, destFromRd=1 and wbFromMem=0 and returns to fetch. An arithmetic instruction takes four cycles.
- R7: If aluOverflow is 1 in execute, the next state is the overflow state (11) and register writeback is not entered. State 11 drives epcWrite=1, causeWrite=1, causeCode=1, pcWrite=1, pcSource=11, aluSrcA=0, aluSrcB=01 and aluOp=01, and then returns to fetch.
- R8: Branch (8) drives aluSrcA=1, aluSrcB=00, aluOp=01, pcWriteCond=1, pcSource=01 and pcWrite=0, and returns to fetch. A branch takes three cycles.
- R9: Jump (9) drives pcWrite=1 and pcSource=10 and returns to fetch. A jump takes three cycles.
- R10: The undefined-instruction state (10) drives epcWrite=1, causeWrite=1, causeCode=0, pcWrite=1, pcSource=11, aluSrcA=0, aluSrcB=01 and aluOp=01, and returns to fetch.
- R11: memRead and memWrite are never 1 together, and pcWrite and pcWriteCond are never 1 together. aluOverflow has no effect in any state other than execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| aluOverflow | input | 1 | Signed overflow flag of the ALU |
| ctrlState | output | 4 | Current state number |
| pcWrite | output | 1 | Unconditional program counter write |
| pcWriteCond | output | 1 | Program counter write when the ALU result is zero |
| irWrite | output | 1 | Instruction register load |
| regWrite | output | 1 | Register file write |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| memAddrSel | output | 1 | Memory address: 0 program counter, 1 ALU output register |
| wbFromMem | output | 1 | Writeback data: 0 ALU output register, 1 memory data register |
| destFromRd | output | 1 | Destination register: 0 rt field, 1 rd field |
| aluSrcA | output | 1 | ALU operand A: 0 program counter, 1 register A |
| aluSrcB | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by two |
| aluOp | output | 2 | 00 add, 01 subtract, 10 take operation from the function field |
| pcSource | output | 2 | Next PC: 00 ALU result, 01 ALU output register, 10 jump target, 11 handler address |
| epcWrite | output | 1 | Save the faulting instruction address |
| causeWrite | output | 1 | Save the exception cause |
| causeCode | output | 1 | Cause value: 0 undefined opcode, 1 overflow |

## Verification
The assertions assume that the opcode input stays stable from decode until the next fetch, as it does when it comes from the instruction register. They also assume that reset is only released at a clock edge that a test has set up. The overflow-entry property relies on aluOverflow being sampled in the execute state. The stimulus changes the opcode and the overflow flag only at an instruction boundary, while the state is fetch. Reset is asserted either at the start or in the middle of an instruction and is held for a whole cycle. The overflow flag is also held high through loads and branches, which shows at the ports that it is ignored outside execute.

// File: rtl/mcCtrlPkg.sv
package mcCtrlPkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH    = 4'd0,
    ST_DECODE   = 4'd1,
    ST_MEMADDR  = 4'd2,
    ST_MEMREAD  = 4'd3,
    ST_LOADWB   = 4'd4,
    ST_MEMWRITE = 4'd5,
    ST_EXEC     = 4'd6,
    ST_RWB      = 4'd7,
    ST_BRANCH   = 4'd8,
    ST_JUMP     = 4'd9,
    ST_UNDEF    = 4'd10,
    ST_OVF      = 4'd11
  } ctrlState_t;

  typedef enum logic [2:0] {
    CL_MEM    = 3'd0,
    CL_RTYPE  = 3'd1,
    CL_BRANCH = 3'd2,
    CL_JUMP   = 3'd3,
    CL_BAD    = 3'd4
  } insnClass_t;

  // ALU operation codes
  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  // operand B selects
  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_IMMSH = 2'b11;

  // next-PC selects
  localparam logic [1:0] PCSRC_ALU     = 2'b00;
  localparam logic [1:0] PCSRC_ALUOUT  = 2'b01;
  localparam logic [1:0] PCSRC_JUMP    = 2'b10;
  localparam logic [1:0] PCSRC_HANDLER = 2'b11;

  localparam logic CAUSE_UNDEF = 1'b0;
  localparam logic CAUSE_OVF   = 1'b1;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       irWrite;
    logic       regWrite;
    logic       memRead;
    logic       memWrite;
    logic       memAddrSel;
    logic       wbFromMem;
    logic       destFromRd;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] aluOp;
    logic [1:0] pcSource;
    logic       epcWrite;
    logic       causeWrite;
    logic       causeCode;
  } ctrlStrobes_t;

endpackage

// File: rtl/insnClassify.sv
module insnClassify
  import mcCtrlPkg::*;
#(
  parameter int             OP_W      = 6,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
  input  logic [OP_W-1:0] opcode,
  output insnClass_t      insnClass,
  output logic            isStore
);

  logic isLoad;

  assign isLoad  = (opcode == OP_LOAD);
  assign isStore = (opcode == OP_STORE);

  always_comb begin
    if (isLoad || isStore)        insnClass = CL_MEM;
    else if (opcode == OP_RTYPE)  insnClass = CL_RTYPE;
    else if (opcode == OP_BRANCH) insnClass = CL_BRANCH;
    else if (opcode == OP_JUMP)   insnClass = CL_JUMP;
    else                          insnClass = CL_BAD;
  end

endmodule

// File: rtl/ctrlSequencer.sv
module ctrlSequencer
  import mcCtrlPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  insnClass_t insnClass,
  input  logic       isStore,
  input  logic       aluOverflow,
  output ctrlState_t curState
);

  ctrlState_t nxtState;

  always_comb begin
    nxtState = ST_FETCH;
    unique case (curState)
      ST_FETCH:   nxtState = ST_DECODE;
      ST_DECODE: begin
        unique case (insnClass)
          CL_MEM:    nxtState = ST_MEMADDR;
          CL_RTYPE:  nxtState = ST_EXEC;
          CL_BRANCH: nxtState = ST_BRANCH;
          CL_JUMP:   nxtState = ST_JUMP;
          default:   nxtState = ST_UNDEF;
        endcase
      end
      ST_MEMADDR: nxtState = isStore ? ST_MEMWRITE : ST_MEMREAD;
      ST_MEMREAD: nxtState = ST_LOADWB;
      ST_EXEC:    nxtState = aluOverflow ? ST_OVF : ST_RWB;
      default:    nxtState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_FETCH;
    else     curState <= nxtState;
  end

endmodule

// File: rtl/strobeDecode.sv
module strobeDecode
  import mcCtrlPkg::*;
(
  input  logic         rst,
  input  ctrlState_t   curState,
  output ctrlStrobes_t strobes
);

  ctrlStrobes_t raw;

  always_comb begin
    raw = '0;
    unique case (curState)
      ST_FETCH: begin
        raw.memRead  = 1'b1;
        raw.irWrite  = 1'b1;
        raw.pcWrite  = 1'b1;
        raw.aluSrcB  = SRCB_FOUR;
        raw.aluOp    = ALU_ADD;
        raw.pcSource = PCSRC_ALU;
      end
      ST_DECODE: begin
        raw.aluSrcB = SRCB_IMMSH;
        raw.aluOp   = ALU_ADD;
      end
      ST_MEMADDR: begin
        raw.aluSrcA = 1'b1;
        raw.aluSrcB = SRCB_IMM;
        raw.aluOp   = ALU_ADD;
      end
      ST_MEMREAD: begin
        raw.memRead    = 1'b1;
        raw.memAddrSel = 1'b1;
      end
      ST_LOADWB: begin
        raw.regWrite  = 1'b1;
        raw.wbFromMem = 1'b1;
      end
      ST_MEMWRITE: begin
        raw.memWrite   = 1'b1;
        raw.memAddrSel = 1'b1;
      end
      ST_EXEC: begin
        raw.aluSrcA = 1'b1;
        raw.aluSrcB = SRCB_REG;
        raw.aluOp   = ALU_FUNC;
      end
      ST_RWB: begin
        raw.regWrite   = 1'b1;
        raw.destFromRd = 1'b1;
      end
      ST_BRANCH: begin
        raw.aluSrcA     = 1'b1;
        raw.aluSrcB     = SRCB_REG;
        raw.aluOp       = ALU_SUB;
        raw.pcWriteCond = 1'b1;
        raw.pcSource    = PCSRC_ALUOUT;
      end
      ST_JUMP: begin
        raw.pcWrite  = 1'b1;
        raw.pcSource = PCSRC_JUMP;
      end
      ST_UNDEF, ST_OVF: begin
        // PC already advanced by four: subtract four to recover the faulting address
        raw.aluSrcB    = SRCB_FOUR;
        raw.aluOp      = ALU_SUB;
        raw.epcWrite   = 1'b1;
        raw.causeWrite = 1'b1;
        raw.causeCode  = (curState == ST_OVF) ? CAUSE_OVF : CAUSE_UNDEF;
        raw.pcWrite    = 1'b1;
        raw.pcSource   = PCSRC_HANDLER;
      end
      default: raw = '0;
    endcase
  end

  assign strobes = rst ? '0 : raw;

endmodule

// File: rtl/multicycleControl.sv
module multicycleControl
  import mcCtrlPkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            aluOverflow,
  output logic [3:0]      ctrlState,
  output logic            pcWrite,
  output logic            pcWriteCond,
  output logic            irWrite,
  output logic            regWrite,
  output logic            memRead,
  output logic            memWrite,
  output logic            memAddrSel,
  output logic            wbFromMem,
  output logic            destFromRd,
  output logic            aluSrcA,
  output logic [1:0]      aluSrcB,
  output logic [1:0]      aluOp,
  output logic [1:0]      pcSource,
  output logic            epcWrite,
  output logic            causeWrite,
  output logic            causeCode
);

  insnClass_t   insnClass;
  logic         isStore;
  ctrlState_t   curState;
  ctrlStrobes_t strobes;

  insnClassify #(.OP_W(OP_W)) uClassify (
    .opcode    (opcode),
    .insnClass (insnClass),
    .isStore   (isStore)
  );

  ctrlSequencer uSeq (
    .clk         (clk),
    .rst         (rst),
    .insnClass   (insnClass),
    .isStore     (isStore),
    .aluOverflow (aluOverflow),
    .curState    (curState)
  );

  strobeDecode uDecode (
    .rst      (rst),
    .curState (curState),
    .strobes  (strobes)
  );

  assign ctrlState   = curState;
  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign irWrite     = strobes.irWrite;
  assign regWrite    = strobes.regWrite;
  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign memAddrSel  = strobes.memAddrSel;
  assign wbFromMem   = strobes.wbFromMem;
  assign destFromRd  = strobes.destFromRd;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign aluOp       = strobes.aluOp;
  assign pcSource    = strobes.pcSource;
  assign epcWrite    = strobes.epcWrite;
  assign causeWrite  = strobes.causeWrite;
  assign causeCode   = strobes.causeCode;

endmodule

// File: rtl/ctrlChecker.sv
module ctrlChecker
  import mcCtrlPkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       aluOverflow,
  input logic [3:0] ctrlState,
  input logic       pcWrite,
  input logic       pcWriteCond,
  input logic       irWrite,
  input logic       regWrite,
  input logic       memRead,
  input logic       memWrite,
  input logic [1:0] pcSource,
  input logic       epcWrite,
  input logic       causeWrite,
  input logic       causeCode
);

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> ctrlState == ST_FETCH);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> !(pcWrite || pcWriteCond || irWrite || regWrite || memRead || memWrite || epcWrite || causeWrite));

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlState == ST_FETCH |=> ctrlState == ST_DECODE);

  // R11
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst) !(memRead && memWrite));

  // R11
  pc_excl_chk: assert property (@(posedge clk) disable iff (rst) !(pcWrite && pcWriteCond));

  // R7
  ovf_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlState == ST_OVF |-> ($past(ctrlState) == ST_EXEC) && $past(aluOverflow));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ctrlState == ST_OVF |-> causeCode && epcWrite);

  // R10
  trap_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    epcWrite |-> causeWrite && pcWrite && (pcSource == PCSRC_HANDLER));

  // R6
  wb_state_chk: assert property (@(posedge clk) disable iff (rst)
    regWrite |-> (ctrlState == ST_LOADWB) || (ctrlState == ST_RWB));

endmodule

bind multicycleControl ctrlChecker chk (
  .clk         (clk),
  .rst         (rst),
  .aluOverflow (aluOverflow),
  .ctrlState   (ctrlState),
  .pcWrite     (pcWrite),
  .pcWriteCond (pcWriteCond),
  .irWrite     (irWrite),
  .regWrite    (regWrite),
  .memRead     (memRead),
  .memWrite    (memWrite),
  .pcSource    (pcSource),
  .epcWrite    (epcWrite),
  .causeWrite  (causeWrite),
  .causeCode   (causeCode)
);

// File: tb/tb_multicycleControl.sv
`timescale 1ns/1ps
module tb_multicycleControl;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic       aluOverflow;
  logic [3:0] ctrlState;
  logic pcWrite, pcWriteCond, irWrite, regWrite, memRead, memWrite;
  logic memAddrSel, wbFromMem, destFromRd, aluSrcA;
  logic [1:0] aluSrcB, aluOp, pcSource;
  logic epcWrite, causeWrite, causeCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int          st;
    string       tag;
  } item_t;

  item_t expQ[$];

  always #2.5 clk = ~clk;

  multicycleControl dut (
    .clk(clk), .rst(rst), .opcode(opcode), .aluOverflow(aluOverflow),
    .ctrlState(ctrlState), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
    .irWrite(irWrite), .regWrite(regWrite), .memRead(memRead), .memWrite(memWrite),
    .memAddrSel(memAddrSel), .wbFromMem(wbFromMem), .destFromRd(destFromRd),
    .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp), .pcSource(pcSource),
    .epcWrite(epcWrite), .causeWrite(causeWrite), .causeCode(causeCode)
  );

  // order: pcWrite pcWriteCond irWrite regWrite memRead memWrite epcWrite causeWrite
  //        causeCode memAddrSel wbFromMem destFromRd aluSrcA aluSrcB aluOp pcSource
  function automatic logic [18:0] observed();
    return {pcWrite, pcWriteCond, irWrite, regWrite, memRead, memWrite, epcWrite,
            causeWrite, causeCode, memAddrSel, wbFromMem, destFromRd, aluSrcA,
            aluSrcB, aluOp, pcSource};
  endfunction

  function automatic logic [18:0] pack(
    input logic pcW, input logic pcWC, input logic irW, input logic rW,
    input logic mR, input logic mW, input logic eW, input logic cW, input logic cC,
    input logic mA, input logic wM, input logic dR, input logic sA,
    input logic [1:0] sB, input logic [1:0] op, input logic [1:0] ps);
    return {pcW, pcWC, irW, rW, mR, mW, eW, cW, cC, mA, wM, dR, sA, sB, op, ps};
  endfunction

  // expected outputs per state, taken from R2..R10
  function automatic logic [18:0] expStrobes(input int st);
    case (st)
      0:  return pack(1,0,1,0,1,0,0,0,0,0,0,0,0,2'b01,2'b00,2'b00); // R2
      1:  return pack(0,0,0,0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00); // R3
      2:  return pack(0,0,0,0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00); // R4
      3:  return pack(0,0,0,0,1,0,0,0,0,1,0,0,0,2'b00,2'b00,2'b00); // R4
      4:  return pack(0,0,0,1,0,0,0,0,0,0,1,0,0,2'b00,2'b00,2'b00); // R4
      5:  return pack(0,0,0,0,0,1,0,0,0,1,0,0,0,2'b00,2'b00,2'b00); // R5
      6:  return pack(0,0,0,0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00); // R6
      7:  return pack(0,0,0,1,0,0,0,0,0,0,0,1,0,2'b00,2'b00,2'b00); // R6
      8:  return pack(0,1,0,0,0,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01); // R8
      9:  return pack(1,0,0,0,0,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10); // R9
      10: return pack(1,0,0,0,0,0,1,1,0,0,0,0,0,2'b01,2'b01,2'b11); // R10
      11: return pack(1,0,0,0,0,0,1,1,1,0,0,0,0,2'b01,2'b01,2'b11); // R7
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int st, input string tag);
    item_t it;
    it.st  = st;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // called at a falling edge while the design sits in fetch
  task automatic runInsn(input logic [5:0] op, input logic ovf, input string tag,
                         input int n, input int s2, input int s3, input int s4);
    opcode      = op;
    aluOverflow = ovf;
    push(0, tag);
    push(1, tag);
    if (n > 2) push(s2, tag);
    if (n > 3) push(s3, tag);
    if (n > 4) push(s4, tag);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares one expected item per cycle, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(ctrlState == 4'(it.st), it.tag, "state", int'(ctrlState), it.st);
        check(observed() == expStrobes(it.st), it.tag, "strobes",
              int'(observed()), int'(expStrobes(it.st)));
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    opcode = 6'b000000;
    aluOverflow = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(ctrlState == 4'd0, "R1", "reset state", int'(ctrlState), 0);
    check(observed() == '0, "R1", "reset strobes", int'(observed()), 0);
    @(negedge clk);
    rst = 1'b0;

    runInsn(6'b100011, 1'b0, "R4_load", 5, 2, 3, 4);
    runInsn(6'b101011, 1'b0, "R5_store", 4, 2, 5, 0);
    runInsn(6'b000000, 1'b0, "R6_rtype", 4, 6, 7, 0);
    runInsn(6'b000000, 1'b1, "R7_overflow", 4, 6, 11, 0);
    runInsn(6'b000100, 1'b0, "R8_branch", 3, 8, 0, 0);
    runInsn(6'b000010, 1'b0, "R9_jump", 3, 9, 0, 0);
    runInsn(6'b111111, 1'b0, "R10_undef", 3, 10, 0, 0);
    runInsn(6'b000001, 1'b0, "R3_decode_undef", 3, 10, 0, 0);
    runInsn(6'b100010, 1'b0, "R3_near_load", 3, 10, 0, 0);
    // overflow flag held high outside execute must not alter the sequence
    runInsn(6'b100011, 1'b1, "R11_load_ovf", 5, 2, 3, 4);
    runInsn(6'b000100, 1'b1, "R11_branch_ovf", 3, 8, 0, 0);
    runInsn(6'b101011, 1'b1, "R11_store_ovf", 4, 2, 5, 0);
    runInsn(6'b000000, 1'b0, "R6_rtype_again", 4, 6, 7, 0);

    // R1 reset in the middle of an arithmetic instruction
    opcode = 6'b000000;
    aluOverflow = 1'b0;
    push(0, "R1_pre");
    push(1, "R1_pre");
    repeat (2) @(negedge clk);
    rst = 1'b1;
    #1;
    check(ctrlState == 4'd6, "R1", "state before edge", int'(ctrlState), 6);
    check(observed() == '0, "R1", "strobes held low", int'(observed()), 0);
    @(negedge clk);
    #1;
    check(ctrlState == 4'd0, "R1", "state after reset", int'(ctrlState), 0);
    check(observed() == '0, "R1", "strobes after reset", int'(observed()), 0);
    @(negedge clk);
    rst = 1'b0;
    runInsn(6'b000010, 1'b0, "R1_recover_jump", 3, 9, 0, 0);

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule